// File: doc/BRIEF.md
# Johnson Decade Counter with Count Inhibit

This block divides a count input by ten using a five-stage twisted-ring (Johnson) register. It runs entirely on a fast system clock: the count input and the inhibit input are sampled there, and the counter advances once for every rising edge of the combined level "count input high and inhibit low". As a result, a rising edge on the count input counts while inhibit is low. A falling edge on inhibit counts while the count input is held high. Both ways of counting share one edge detector.

The block presents the raw Johnson state and a decoded digit from 0 to 9. It also drives a carry square wave at one tenth of the count rate, and that wave can serve as the count input of the next decade. An active-high asynchronous reset returns the block to digit zero. Any pattern outside the ten legal ones is sent back to zero on the next count.

Top module: `johnson_decade`

## Requirements
- R1: The state steps through exactly ten patterns, bit 0 being the first stage: 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, then back to 00000. Each count moves it one place.
- R2: While `rst` is high, the state is 00000 at once, without waiting for a clock. Count edges while `rst` is high have no effect, and after release a level that is already high does not count.
- R3: With `cnt_inh` low, a rising edge of `cnt_clk` advances the state by one place. The new state shows after the first `clk` rising edge that samples the new level.
- R4: While `cnt_inh` is high, toggling `cnt_clk` leaves the state unchanged.
- R5: With `cnt_clk` held high, a falling edge of `cnt_inh` advances the state by one place, and a rising edge of `cnt_inh` does not.
- R6: Only the ten legal patterns ever appear on `johnson`. Any illegal pattern is replaced by 00000 on the next count.
- R7: `digit` gives the position of the state in the R1 sequence, as an unsigned value from 0 to 9.
- R8: `carry` is high for digits 0 to 4 and low for digits 5 to 9, so its rising edge marks the wrap from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst | input | 1 | Asynchronous reset to digit zero, active high |
| cnt_clk | input | 1 | Count input, active on its rising edge |
| cnt_inh | input | 1 | Count inhibit; its falling edge counts when cnt_clk is high |
| johnson | output | 5 | Twisted-ring state |
| digit | output | 4 | Decoded count 0 to 9 |
| carry | output | 1 | Divide-by-ten output, high for counts 0 to 4 |

## Verification
Directed sequences run the count input through more than one full turn of ten, so every pattern, every digit and the carry rise at the wrap are each seen once. Further sequences toggle the count input with inhibit high, and others drive inhibit edges in both directions with the count input high; together these separate the two counting paths from gating that leaks. A reset raised between clock edges shows that the clear is asynchronous, and count edges during reset and right after release show that reset has priority. Long random runs then mix the two inputs freely, with occasional resets, which catches double counts and missed counts when both inputs change in the same cycle.

// File: rtl/johnson_decade.sv
module johnson_decade #(
  parameter int STAGES = 5,
  localparam int MOD = 2 * STAGES,
  localparam int DW = $clog2(MOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_clk,
  input  logic              cnt_inh,
  output logic [STAGES-1:0] johnson,
  output logic [DW-1:0]     digit,
  output logic              carry
);

  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  logic              lvl, lvl_q, step, legal;
  logic [STAGES-1:0] q, q_inv, q_nxt;
  logic [DW-1:0]     ones;

  assign lvl   = cnt_clk & ~cnt_inh;
  assign step  = lvl & ~lvl_q;

  assign q_inv = ~q;
  assign legal = ((q & (q + ONE)) == '0) || ((q_inv & (q_inv + ONE)) == '0);
  assign q_nxt = legal ? {q[STAGES-2:0], ~q[STAGES-1]} : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lvl_q <= 1'b1;
      q     <= '0;
    end else begin
      lvl_q <= lvl;
      if (step) q <= q_nxt;
    end
  end

  always_comb begin
    ones = '0;
    for (int k = 0; k < STAGES; k++) ones = ones + DW'(q[k]);
  end

  always_comb begin
    if (!legal)        digit = '1;
    else if (q[0])     digit = ones;
    else if (q == '0)  digit = '0;
    else               digit = DW'(MOD) - ones;
  end

  assign johnson = q;
  assign carry   = ~q[STAGES-1];

endmodule

// File: rtl/johnson_decade_chk.sv
module johnson_decade_chk #(
  parameter int STAGES = 5,
  localparam int MOD = 2 * STAGES,
  localparam int DW = $clog2(MOD)
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_clk,
  input logic              cnt_inh,
  input logic [STAGES-1:0] johnson,
  input logic [DW-1:0]     digit,
  input logic              carry
);

  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  function automatic logic [STAGES-1:0] pat(int k);
    if (k <= STAGES) return (ONE << k) - ONE;
    return ~((ONE << (k - STAGES)) - ONE);
  endfunction

  logic [STAGES-1:0] nxt_pat;
  assign nxt_pat = pat((int'(digit) + 1) % MOD);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |-> johnson == '0);  // R2
  AST_NO_COUNT_INHIBITED: assert property (@(posedge clk) disable iff (rst)
    cnt_inh |=> johnson == $past(johnson));  // R4
  AST_NO_COUNT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !cnt_clk |=> johnson == $past(johnson));  // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (johnson == $past(johnson) || johnson == $past(nxt_pat)));  // R1
  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    int'(digit) < MOD);  // R6
  AST_DIGIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    johnson == pat(int'(digit)));  // R7
  AST_CARRY_PHASE: assert property (@(posedge clk) disable iff (rst)
    carry == (int'(digit) < STAGES));  // R8

endmodule

bind johnson_decade johnson_decade_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/johnson_decade_tb.sv
module johnson_decade_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_clk = 1'b0;
  logic       cnt_inh = 1'b0;
  logic [4:0] johnson;
  logic [3:0] digit;
  logic       carry;

  int e = 0;
  bit pm = 1'b1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  johnson_decade u_dut (.*);

  function automatic logic [4:0] pat(int k);
    logic [4:0] p = '0;
    for (int b = 0; b < 5; b++) p[b] = (k <= 5) ? (b < k) : (b >= k - 5);
    return p;
  endfunction

  function automatic bit is_legal(logic [4:0] v);
    for (int k = 0; k < 10; k++) if (v == pat(k)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req);
    checks++;
    if (johnson !== pat(e) || digit !== 4'(e) || carry !== (e < 5) || !is_legal(johnson)) begin
      fails++;
      $display("FAIL %s: johnson=%b digit=%0d carry=%b expected johnson=%b digit=%0d carry=%b",
               req, johnson, digit, carry, pat(e), e, e < 5);
    end
  endtask

  task automatic apply(bit c, bit i, bit r, string req);
    cnt_clk = c; cnt_inh = i; rst = r;
    if (r) begin
      e = 0; pm = 1'b1;
    end else begin
      if ((c & ~i) && !pm) e = (e + 1) % 10;
      pm = c & ~i;
    end
    @(posedge clk); #2;
    check(req);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D0A));
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset state");
    apply(1, 0, 1, "R2 edge during reset");
    apply(1, 0, 0, "R2 high level after release");
    apply(0, 0, 0, "R3 clk low");
    for (int n = 0; n < 12; n++) begin
      apply(1, 0, 0, "R1 R3 R7 R8 count up");
      apply(0, 0, 0, "R3 falling clk no count");
    end
    for (int n = 0; n < 4; n++) begin
      apply(0, 1, 0, "R4 inhibited low");
      apply(1, 1, 0, "R4 inhibited high");
    end
    for (int n = 0; n < 6; n++) begin
      apply(1, 0, 0, "R5 inhibit falling counts");
      apply(1, 1, 0, "R5 inhibit rising no count");
    end
    apply(0, 0, 0, "R3 idle");
    @(negedge clk);
    rst = 1'b1;
    #0.5;
    checks++;
    if (johnson !== 5'b00000) begin
      fails++;
      $display("FAIL R2 async clear: johnson=%b expected 00000", johnson);
    end
    e = 0; pm = 1'b1;
    apply(0, 0, 1, "R2 held");
    apply(0, 0, 0, "R2 released");
    for (int n = 0; n < 10; n++) apply(~n[0], 0, 0, "R8 carry wrap");
    for (int n = 0; n < 6000; n++) begin
      bit c = ($urandom % 3) != 0 ? ~cnt_clk : cnt_clk;
      bit i = ($urandom % 4) == 0 ? ~cnt_inh : cnt_inh;
      bit r = ($urandom % 250) == 0;
      apply(c, i, r, "R1 R3 R4 R5 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule